// File: doc/BRIEF.md
# Local Interrupt Acceptance and Arbitration

This block collects interrupt requests aimed at one processor core and decides which of them the core should take next. Each request carries an 8-bit vector, a 3-bit delivery mode and a flag that says whether it is level- or edge-triggered. The two maskable modes queue the request in a 256-entry request register indexed by vector. A trigger-mode register beside it records, for each queued vector, how that vector was signalled. A running register keeps the highest maskable vector seen since reset.

Four special modes do not use the request register. These are system-management, non-maskable, init and external. Each has a single-entry pending latch that holds the first vector to arrive. Three of them also set a shared summary flag marking that an unmaskable event is waiting.

A service port shows the winning source and its vector. The core clears that source by pulsing an acknowledge input for one cycle. A request is accepted on the rising clock edge where `req_valid` is high, and its effect shows on the outputs after that edge.

Top module: `irq_accept`

## Requirements
- R1: Delivery modes 000 (fixed) and 001 (lowest priority) set bit `req_vector` of `req_bits`. No other mode changes `req_bits`.
- R2: A maskable request for a vector whose request bit is already set changes neither that request bit nor its trigger-mode bit.
- R3: When a maskable request queues a new vector, bit `req_vector` of `trig_bits` becomes `req_level`: 1 for level-triggered, 0 for edge-triggered.
- R4: `top_vector` takes the vector of a maskable request only when that vector is greater than its current value. It never decreases, and special modes leave it alone.
- R5: Modes 010 (system-management), 100 (non-maskable) and 101 (init) each set their own pending latch, capture the vector and raise `unmask_pending`.
- R6: Mode 111 (external) sets its pending latch and captures the vector without raising `unmask_pending`.
- R7: A special-mode request that arrives while the same mode is still pending is dropped, and the vector captured first is kept.
- R8: Modes 011 and 110 are reserved. A reserved request changes no state and no output.
- R9: `svc_kind` names the winner in a fixed order: 1 system-management, 2 non-maskable, 3 init, 4 external, 5 maskable, 0 nothing pending. For kind 5, `svc_vector` is the highest set bit of `req_bits`.
- R10: A one-cycle `ack` clears only the source shown on the service port. For kind 5 that is the request bit of `svc_vector`. `unmask_pending` falls once none of modes 010, 100 or 101 is still pending.
- R11: After reset nothing is pending, `svc_valid` and `unmask_pending` are 0, and `req_bits`, `trig_bits` and `top_vector` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered this cycle |
| req_vector | input | 8 | Vector of the request |
| req_mode | input | 3 | Delivery mode of the request |
| req_level | input | 1 | 1 level-triggered, 0 edge-triggered |
| ack | input | 1 | Core takes the source shown on the service port |
| svc_valid | output | 1 | Some source is pending |
| svc_kind | output | 3 | Winning source code |
| svc_vector | output | 8 | Vector of the winning source |
| unmask_pending | output | 1 | System-management, non-maskable or init pending |
| top_vector | output | 8 | Highest maskable vector seen since reset |
| req_bits | output | 256 | Maskable request register |
| trig_bits | output | 256 | Trigger-mode register |

## Verification
The properties assume that `ack` is raised only while `svc_valid` is high. They also assume that `ack` never arrives in the same cycle as a request of the mode it would clear. Both would otherwise make the hold-and-drop checks ambiguous.

The directed stimulus follows these rules. It holds each request for exactly one clock. It keeps a gap between any request and any acknowledge. It acknowledges only after reading a valid service port. Every scenario is built in that one-event-per-cycle form.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  localparam int unsigned MODE_W = 3;
  localparam int unsigned NUM_SPECIAL = 4;

  localparam logic [MODE_W-1:0] DM_FIXED  = 3'b000;
  localparam logic [MODE_W-1:0] DM_LOWEST = 3'b001;
  localparam logic [MODE_W-1:0] DM_SMI    = 3'b010;
  localparam logic [MODE_W-1:0] DM_NMI    = 3'b100;
  localparam logic [MODE_W-1:0] DM_INIT   = 3'b101;
  localparam logic [MODE_W-1:0] DM_EXT    = 3'b111;

  // special slot index is also the priority rank (0 wins)
  localparam int unsigned SLOT_SMI  = 0;
  localparam int unsigned SLOT_NMI  = 1;
  localparam int unsigned SLOT_INIT = 2;
  localparam int unsigned SLOT_EXT  = 3;
  localparam int unsigned NUM_UNMASK = 3;

  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_SMI   = 3'd1,
    KIND_NMI   = 3'd2,
    KIND_INIT  = 3'd3,
    KIND_EXT   = 3'd4,
    KIND_FIXED = 3'd5
  } svc_kind_e;

  function automatic logic mode_is_maskable(input logic [MODE_W-1:0] m);
    return (m == DM_FIXED) || (m == DM_LOWEST);
  endfunction

  function automatic logic [MODE_W-1:0] slot_mode(input int unsigned slot);
    case (slot)
      SLOT_SMI:  return DM_SMI;
      SLOT_NMI:  return DM_NMI;
      SLOT_INIT: return DM_INIT;
      default:   return DM_EXT;
    endcase
  endfunction

  function automatic svc_kind_e slot_kind(input int unsigned slot);
    case (slot)
      SLOT_SMI:  return KIND_SMI;
      SLOT_NMI:  return KIND_NMI;
      SLOT_INIT: return KIND_INIT;
      default:   return KIND_EXT;
    endcase
  endfunction

  function automatic logic mode_is_reserved(input logic [MODE_W-1:0] m);
    return (m == 3'b011) || (m == 3'b110);
  endfunction

endpackage

// File: rtl/irq_vec_store.sv
module irq_vec_store #(
  parameter int unsigned VEC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [VEC_W-1:0]   set_vec,
  input  logic               set_level,
  input  logic               clr_en,
  input  logic [VEC_W-1:0]   clr_vec,
  output logic [(1<<VEC_W)-1:0] req_q,
  output logic [(1<<VEC_W)-1:0] trig_q,
  output logic [VEC_W-1:0]   top_q,
  output logic               any_req,
  output logic [VEC_W-1:0]   high_vec
);
  localparam int unsigned NUM_VEC = 1 << VEC_W;

  // named events for the properties
  logic dup_hit;
  logic new_hit;
  assign dup_hit = set_en &  req_q[set_vec];
  assign new_hit = set_en & ~req_q[set_vec];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      trig_q <= '0;
      top_q  <= '0;
    end else begin
      if (clr_en) req_q[clr_vec] <= 1'b0;
      if (set_en && (set_vec > top_q)) top_q <= set_vec;
      if (new_hit) begin
        req_q[set_vec]  <= 1'b1;
        trig_q[set_vec] <= set_level;
      end
    end
  end

  // highest set request bit
  always_comb begin
    any_req  = 1'b0;
    high_vec = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (req_q[i]) begin
        any_req  = 1'b1;
        high_vec = VEC_W'(i);
      end
    end
  end

  // checker state: remember last event for one-cycle-later comparison
  logic             chk_dup, chk_new, chk_lvl, chk_trig;
  logic [VEC_W-1:0] chk_vec;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_dup <= 1'b0; chk_new <= 1'b0; chk_lvl <= 1'b0;
      chk_trig <= 1'b0; chk_vec <= '0;
    end else begin
      chk_dup  <= dup_hit && !(clr_en && clr_vec == set_vec);
      chk_new  <= new_hit;
      chk_lvl  <= set_level;
      chk_trig <= trig_q[set_vec];
      chk_vec  <= set_vec;
    end
  end

  a_r2_dup_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    chk_dup |-> (req_q[chk_vec] && trig_q[chk_vec] == chk_trig));

  a_r3_new_trig: assert property (@(posedge clk) disable iff (!rst_n)
    chk_new |-> (req_q[chk_vec] && trig_q[chk_vec] == chk_lvl));

  a_r4_top_mono: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (top_q >= $past(top_q)));

endmodule

// File: rtl/irq_special_latch.sv
module irq_special_latch #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [VEC_W-1:0] vec_in,
  input  logic             clr,
  output logic             pend_q,
  output logic [VEC_W-1:0] vec_q
);
  logic accept;
  assign accept = take & ~pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (clr) pend_q <= 1'b0;
      if (accept) begin
        pend_q <= 1'b1;
        vec_q  <= vec_in;
      end
    end
  end

  a_r7_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pend_q && !clr) |=> (pend_q && $stable(vec_q)));

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pend_q && vec_q == $past(vec_in)));

endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_accept_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_SPECIAL-1:0]              sp_pend,
  input  logic [NUM_SPECIAL-1:0][VEC_W-1:0]   sp_vec,
  input  logic                                fx_any,
  input  logic [VEC_W-1:0]                    fx_vec,
  input  logic                                ack,
  output logic                                valid,
  output svc_kind_e                           kind,
  output logic [VEC_W-1:0]                    vector,
  output logic [NUM_SPECIAL-1:0]              sp_clr,
  output logic                                fx_clr
);
  logic [NUM_SPECIAL-1:0] sp_win;

  // fixed order: lowest slot index wins
  always_comb begin
    sp_win = '0;
    for (int s = NUM_SPECIAL - 1; s >= 0; s--) begin
      if (sp_pend[s]) sp_win = NUM_SPECIAL'(1) << s;
    end
  end

  always_comb begin
    kind   = KIND_NONE;
    vector = '0;
    for (int s = 0; s < NUM_SPECIAL; s++) begin
      if (sp_win[s]) begin
        kind   = slot_kind(s);
        vector = sp_vec[s];
      end
    end
    if (sp_win == '0 && fx_any) begin
      kind   = KIND_FIXED;
      vector = fx_vec;
    end
  end

  assign valid  = (kind != KIND_NONE);
  assign sp_clr = ack ? sp_win : '0;
  assign fx_clr = ack && (kind == KIND_FIXED);

  a_r9_fixed_last: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == KIND_FIXED) |-> (sp_pend == '0));

  a_r9_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sp_win) && (sp_pend != '0 || !fx_any || kind == KIND_FIXED));

  a_r10_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ($countones({sp_clr, fx_clr}) == 1));

endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_accept_pkg::*;
#(
  parameter int unsigned VEC_W = 8,
  localparam int unsigned NUM_VEC = 1 << VEC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VEC_W-1:0]   req_vector,
  input  logic [MODE_W-1:0]  req_mode,
  input  logic               req_level,
  input  logic               ack,
  output logic               svc_valid,
  output logic [2:0]         svc_kind,
  output logic [VEC_W-1:0]   svc_vector,
  output logic               unmask_pending,
  output logic [VEC_W-1:0]   top_vector,
  output logic [NUM_VEC-1:0] req_bits,
  output logic [NUM_VEC-1:0] trig_bits
);
  // decoded request events
  logic                        mask_take;
  logic                        rsv_seen;
  logic [NUM_SPECIAL-1:0]      sp_take;
  logic [NUM_SPECIAL-1:0]      sp_pend;
  logic [NUM_SPECIAL-1:0][VEC_W-1:0] sp_vec;
  logic [NUM_SPECIAL-1:0]      sp_clr;
  logic                        fx_any, fx_clr;
  logic [VEC_W-1:0]            fx_vec;
  svc_kind_e                   kind;

  assign mask_take = req_valid && mode_is_maskable(req_mode);
  assign rsv_seen  = req_valid && mode_is_reserved(req_mode);

  irq_vec_store #(.VEC_W(VEC_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (mask_take),
    .set_vec  (req_vector),
    .set_level(req_level),
    .clr_en   (fx_clr),
    .clr_vec  (fx_vec),
    .req_q    (req_bits),
    .trig_q   (trig_bits),
    .top_q    (top_vector),
    .any_req  (fx_any),
    .high_vec (fx_vec)
  );

  for (genvar s = 0; s < NUM_SPECIAL; s++) begin : g_special
    assign sp_take[s] = req_valid && (req_mode == slot_mode(s));
    irq_special_latch #(.VEC_W(VEC_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (sp_take[s]),
      .vec_in(req_vector),
      .clr   (sp_clr[s]),
      .pend_q(sp_pend[s]),
      .vec_q (sp_vec[s])
    );
  end

  irq_select #(.VEC_W(VEC_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .sp_pend(sp_pend),
    .sp_vec(sp_vec),
    .fx_any(fx_any),
    .fx_vec(fx_vec),
    .ack   (ack),
    .valid (svc_valid),
    .kind  (kind),
    .vector(svc_vector),
    .sp_clr(sp_clr),
    .fx_clr(fx_clr)
  );
  assign svc_kind = kind;

  // summary flag kept as its own set/clear register
  logic [NUM_UNMASK-1:0] um_new;
  logic [NUM_UNMASK-1:0] um_left;
  logic                  um_drop;
  assign um_new  = sp_take[NUM_UNMASK-1:0] & ~sp_pend[NUM_UNMASK-1:0];
  assign um_left = sp_pend[NUM_UNMASK-1:0] & ~sp_clr[NUM_UNMASK-1:0];
  assign um_drop = (sp_clr[NUM_UNMASK-1:0] != '0) && (um_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              unmask_pending <= 1'b0;
    else if (um_new != '0)   unmask_pending <= 1'b1;
    else if (um_drop)        unmask_pending <= 1'b0;
  end

  a_r5_summary: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_pending == (sp_pend[NUM_UNMASK-1:0] != '0));

  a_r6_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_take[SLOT_EXT] && sp_pend[NUM_UNMASK-1:0] == '0 &&
     sp_take[NUM_UNMASK-1:0] == '0) |=> !unmask_pending);

  a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_seen && !ack) |=> ($stable(req_bits) && $stable(trig_bits) &&
                            $stable(sp_pend) && $stable(top_vector)));

  a_r1_special_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mode_is_maskable(req_mode) && !ack) |=> $stable(req_bits));

endmodule

// File: tb/irq_accept_test.sv
module irq_accept_test;
  localparam int unsigned PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [7:0]   req_vector = '0;
  logic [2:0]   req_mode = '0;
  logic         req_level = 1'b0;
  logic         ack = 1'b0;
  logic         svc_valid;
  logic [2:0]   svc_kind;
  logic [7:0]   svc_vector;
  logic         unmask_pending;
  logic [7:0]   top_vector;
  logic [255:0] req_bits;
  logic [255:0] trig_bits;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  irq_accept uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .req_mode(req_mode), .req_level(req_level), .ack(ack),
    .svc_valid(svc_valid), .svc_kind(svc_kind), .svc_vector(svc_vector),
    .unmask_pending(unmask_pending), .top_vector(top_vector),
    .req_bits(req_bits), .trig_bits(trig_bits)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one-cycle request; returns at the next falling edge, outputs settled
  task automatic send(input logic [7:0] v, input logic [2:0] m, input logic lvl);
    @(negedge clk);
    req_valid = 1'b1; req_vector = v; req_mode = m; req_level = lvl;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 svc_valid", svc_valid, 0);
    check("R11 unmask", unmask_pending, 0);
    check("R11 top", top_vector, 0);
    check("R11 req ones", $countones(req_bits), 0);
    check("R11 trig ones", $countones(trig_bits), 0);
  endtask

  task automatic t_fixed();
    send(8'h40, 3'b000, 1'b1);
    check("R1 req[40]", req_bits[8'h40], 1);
    check("R3 level trig[40]", trig_bits[8'h40], 1);
    check("R4 top", top_vector, 8'h40);
    check("R9 kind fixed", svc_kind, 5);
    check("R9 vec", svc_vector, 8'h40);
  endtask

  task automatic t_lowest();
    send(8'h20, 3'b001, 1'b0);
    check("R1 req[20]", req_bits[8'h20], 1);
    check("R3 edge trig[20]", trig_bits[8'h20], 0);
    check("R4 top not lowered", top_vector, 8'h40);
    check("R9 highest vec", svc_vector, 8'h40);
  endtask

  task automatic t_dup();
    send(8'h40, 3'b000, 1'b0);
    check("R2 trig kept", trig_bits[8'h40], 1);
    check("R2 req count", $countones(req_bits), 2);
  endtask

  task automatic t_special();
    send(8'h02, 3'b100, 1'b1);
    check("R5 nmi kind", svc_kind, 2);
    check("R5 nmi vec", svc_vector, 8'h02);
    check("R5 summary", unmask_pending, 1);
    check("R1 special no req", $countones(req_bits), 2);
    check("R4 special no top", top_vector, 8'h40);
    send(8'h09, 3'b100, 1'b0);
    check("R7 nmi first kept", svc_vector, 8'h02);
    send(8'h05, 3'b010, 1'b0);
    check("R9 smi wins", svc_kind, 1);
    check("R5 smi vec", svc_vector, 8'h05);
    send(8'h07, 3'b101, 1'b0);
    send(8'h33, 3'b111, 1'b0);
    check("R9 smi still wins", svc_kind, 1);
  endtask

  task automatic t_reserved();
    send(8'hF0, 3'b011, 1'b1);
    send(8'hF1, 3'b110, 1'b1);
    check("R8 req", $countones(req_bits), 2);
    check("R8 trig", $countones(trig_bits), 1);
    check("R8 top", top_vector, 8'h40);
    check("R8 kind", svc_kind, 1);
    check("R8 vec", svc_vector, 8'h05);
  endtask

  task automatic t_ack();
    pulse_ack();
    check("R10 then nmi", svc_kind, 2);
    check("R10 nmi vec", svc_vector, 8'h02);
    check("R10 summary held", unmask_pending, 1);
    pulse_ack();
    check("R10 then init", svc_kind, 3);
    check("R7 init vec", svc_vector, 8'h07);
    check("R10 summary held2", unmask_pending, 1);
    pulse_ack();
    check("R9 then ext", svc_kind, 4);
    check("R9 ext vec", svc_vector, 8'h33);
    check("R10 summary drop", unmask_pending, 0);
    pulse_ack();
    check("R9 then fixed", svc_kind, 5);
    check("R10 fixed vec", svc_vector, 8'h40);
    pulse_ack();
    check("R10 fixed clear", svc_vector, 8'h20);
    check("R10 req[40] gone", req_bits[8'h40], 0);
    pulse_ack();
    check("R10 empty", svc_valid, 0);
    check("R10 kind none", svc_kind, 0);
  endtask

  task automatic t_ext_alone();
    send(8'h11, 3'b111, 1'b0);
    check("R6 ext kind", svc_kind, 4);
    check("R6 ext vec", svc_vector, 8'h11);
    check("R6 no summary", unmask_pending, 0);
    pulse_ack();
    check("R10 ext cleared", svc_valid, 0);
  endtask

  task automatic t_bounds();
    send(8'h00, 3'b000, 1'b1);
    check("R9 vec zero", svc_vector, 0);
    check("R4 top stays", top_vector, 8'h40);
    send(8'hFF, 3'b001, 1'b1);
    check("R4 top max", top_vector, 8'hFF);
    check("R9 vec max", svc_vector, 8'hFF);
    check("R3 trig[FF]", trig_bits[8'hFF], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fixed();
    t_lowest();
    t_dup();
    t_special();
    t_reserved();
    t_ack();
    t_ext_alone();
    t_bounds();
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule